// File: doc/BRIEF.md
# Variable Lane Blend Execution Unit

This SIMD execution unit merges two vectors of 64-bit lanes under a per-lane mask. Each lane of the result comes from the first source or the second source. The sign bit of the matching mask lane makes that choice. One datapath serves three encodings: a legacy 128-bit form, a VEX 128-bit form and a VEX 256-bit form. They differ in how the bits above bit 127 are produced. The legacy form keeps them from the destination, VEX 128 zeroes them, and VEX 256 blends them. The encodings also differ in where the mask register number comes from and in which encodings are rejected as undefined.

An operation enters on a valid/ready input handshake. A legal operation produces a result one cycle after it is accepted. The result is a 256-bit vector together with the decoded mask register index. It sits in a single output register that drains over a valid/ready handshake. While that register is full and the consumer holds `out_ready` low, `in_ready` is low and the held result does not change. An illegal encoding produces no result. Instead, `ud_flag` is pulsed for one cycle.

Top module: `vblend_unit`

## Requirements
- R1: For each 64-bit lane that is blended, the result lane equals the second source lane when the most significant bit of the same mask lane (bit 64*i+63) is 1. It equals the first source lane when that bit is 0. The other mask bits have no effect.
- R2: In legacy mode (`mode`=0), lanes 0 and 1 are blended and the reported mask index is 0 whatever `imm8` holds.
- R3: In legacy mode, result bits 255:128 equal bits 255:128 of the first source, which acts as the destination.
- R4: In VEX 128 mode (`mode`=1), lanes 0 and 1 are blended and result bits 255:128 are zero.
- R5: In VEX 256 mode (`mode`=2), all four lanes are blended, using mask bits 63, 127, 191 and 255.
- R6: In the VEX modes with `mode32`=0, the mask index equals `imm8[7:4]`, and `imm8[3:0]` has no effect on any output.
- R7: In the VEX modes with `mode32`=1, the mask index equals `{1'b0, imm8[6:4]}`, so it lies in the range 0 to 7.
- R8: An accepted operation in a VEX mode with `vex_w`=1 is undefined, and so is any operation with `mode`=3. In legacy mode `vex_w` is ignored.
- R9: An accepted legacy-mode operation with `vex_prefix`=1 is undefined. In the VEX modes `vex_prefix` is ignored.
- R10: An undefined operation raises `ud_flag` for exactly the one cycle after acceptance. It leaves `out_valid` low, and `out_data` and `out_mask_idx` keep their previous values.
- R11: A legal operation accepted at one edge shows `out_valid`=1 with its result after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid`=1 and `out_ready`=0, the output holds its value and its valid. Once drained with no new input, `out_valid` falls.
- R12: A synchronous active-high reset clears `out_valid`, `out_data`, `out_mask_idx` and `ud_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| mode | input | 2 | 0 legacy 128, 1 VEX 128, 2 VEX 256, 3 reserved |
| vex_prefix | input | 1 | Operation arrived with a VEX prefix (checked in legacy mode) |
| vex_w | input | 1 | VEX.W bit (checked in VEX modes) |
| mode32 | input | 1 | Processor is in 32-bit mode |
| imm8 | input | 8 | Immediate byte carrying the mask register number |
| src1 | input | 256 | First source, also the current destination |
| src2 | input | 256 | Second source |
| mask | input | 256 | Mask vector |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Blended result |
| out_mask_idx | output | 4 | Decoded mask register index |
| ud_flag | output | 1 | One-cycle undefined-opcode pulse |

## Verification
The hardest situation to reach from the ports is a stalled output with a new operation pending at the input. The held result has to stay frozen, and the pending operation must be neither lost nor taken early. The bench holds `out_ready` low after a result, keeps a different operation on the input for several cycles, and checks that the output stays frozen before draining it. Apart from that, the bench sweeps every mode, prefix, W bit, 32-bit flag, upper-immediate nibble and lane mask pattern. This covers every legal/illegal boundary and every lane selection.

// File: rtl/vblend_pkg.sv
package vblend_pkg;
  typedef enum logic [1:0] {
    BM_LEGACY = 2'd0,
    BM_VEX128 = 2'd1,
    BM_VEX256 = 2'd2,
    BM_RSVD   = 2'd3
  } blend_mode_e;
endpackage

// File: rtl/vblend_lane_mux.sv
module vblend_lane_mux
  import vblend_pkg::*;
#(
  parameter int LANE_W       = 64,
  parameter int LANES        = 4,
  parameter int NARROW_LANES = 2,
  localparam int VEC_W       = LANE_W * LANES
) (
  input  blend_mode_e      mode,
  input  logic [VEC_W-1:0] src1,
  input  logic [VEC_W-1:0] src2,
  input  logic [VEC_W-1:0] mask,
  output logic [VEC_W-1:0] result
);
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [LANE_W-1:0] keep_lane;
    logic [LANE_W-1:0] take_lane;
    logic [LANE_W-1:0] pick;
    assign keep_lane = src1[gi*LANE_W +: LANE_W];
    assign take_lane = src2[gi*LANE_W +: LANE_W];
    // only the sign bit of the mask lane steers the choice
    assign pick = mask[gi*LANE_W + LANE_W - 1] ? take_lane : keep_lane;
    if (gi < NARROW_LANES) begin : g_low
      assign result[gi*LANE_W +: LANE_W] = pick;
    end else begin : g_high
      logic [LANE_W-1:0] upper;
      always_comb begin
        unique case (mode)
          BM_LEGACY: upper = keep_lane;
          BM_VEX256: upper = pick;
          default:   upper = '0;
        endcase
      end
      assign result[gi*LANE_W +: LANE_W] = upper;
    end
  end
endmodule

// File: rtl/vblend_idx_decode.sv
module vblend_idx_decode
  import vblend_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  blend_mode_e      mode,
  input  logic [IDX_W-1:0] imm_hi,
  input  logic             mode32,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    if (mode == BM_LEGACY) begin
      idx = '0;
    end else if (mode32) begin
      idx = {1'b0, imm_hi[IDX_W-2:0]};
    end else begin
      idx = imm_hi;
    end
  end
endmodule

// File: rtl/vblend_legality.sv
module vblend_legality
  import vblend_pkg::*;
(
  input  blend_mode_e mode,
  input  logic        vex_prefix,
  input  logic        vex_w,
  output logic        illegal
);
  always_comb begin
    unique case (mode)
      BM_LEGACY: illegal = vex_prefix;
      BM_VEX128,
      BM_VEX256: illegal = vex_w;
      default:   illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/vblend_unit.sv
module vblend_unit
  import vblend_pkg::*;
#(
  parameter int LANE_W       = 64,
  parameter int LANES        = 4,
  parameter int NARROW_LANES = 2,
  parameter int IDX_W        = 4,
  localparam int VEC_W       = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       mode,
  input  logic             vex_prefix,
  input  logic             vex_w,
  input  logic             mode32,
  input  logic [7:0]       imm8,
  input  logic [VEC_W-1:0] src1,
  input  logic [VEC_W-1:0] src2,
  input  logic [VEC_W-1:0] mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  output logic [IDX_W-1:0] out_mask_idx,
  output logic             ud_flag
);
  blend_mode_e      mode_e;
  logic [VEC_W-1:0] blend_res;
  logic [IDX_W-1:0] idx_dec;
  logic             illegal;
  logic             accept;
  logic             imm_lo_unused;

  assign mode_e        = blend_mode_e'(mode);
  assign imm_lo_unused = ^imm8[7-IDX_W:0];
  assign in_ready      = !out_valid || out_ready;
  assign accept        = in_valid && in_ready;

  vblend_lane_mux #(
    .LANE_W(LANE_W), .LANES(LANES), .NARROW_LANES(NARROW_LANES)
  ) u_mux (
    .mode(mode_e), .src1(src1), .src2(src2), .mask(mask), .result(blend_res)
  );

  vblend_idx_decode #(.IDX_W(IDX_W)) u_idx (
    .mode(mode_e), .imm_hi(imm8[7:8-IDX_W]), .mode32(mode32), .idx(idx_dec)
  );

  vblend_legality u_legal (
    .mode(mode_e), .vex_prefix(vex_prefix), .vex_w(vex_w), .illegal(illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_mask_idx <= '0;
      ud_flag      <= 1'b0;
    end else begin
      ud_flag <= 1'b0;
      if (accept) begin
        if (illegal) begin
          out_valid <= 1'b0;
          ud_flag   <= 1'b1;
        end else begin
          out_valid    <= 1'b1;
          out_data     <= blend_res;
          out_mask_idx <= idx_dec;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vblend_checker.sv
module vblend_checker #(
  parameter int VEC_W    = 256,
  parameter int NARROW_W = 128,
  parameter int IDX_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       mode,
  input logic             vex_w,
  input logic             mode32,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_data,
  input logic [IDX_W-1:0] out_mask_idx,
  input logic             ud_flag
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mask_idx)); // R11
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R11
  AST_UD_SILENT: assert property (@(posedge clk) disable iff (rst)
    ud_flag |-> !out_valid); // R10
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid && in_ready && mode == 2'd1 && !vex_w)
      |-> out_valid && out_data[VEC_W-1:NARROW_W] == '0); // R4
  AST_IDX_32BIT: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid && in_ready && mode32) && out_valid |-> !out_mask_idx[IDX_W-1]); // R7
  AST_LEGACY_IDX: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid && in_ready && mode == 2'd0) && out_valid |-> out_mask_idx == '0); // R2
  AST_VEXW_UD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && in_valid && in_ready && mode != 2'd0 && vex_w) |-> ud_flag); // R8
endmodule

bind vblend_unit vblend_checker #(
  .VEC_W(VEC_W), .NARROW_W(NARROW_LANES*LANE_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .mode(mode),
  .vex_w(vex_w), .mode32(mode32), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_mask_idx(out_mask_idx), .ud_flag(ud_flag)
);

// File: tb/tb_vblend_unit.sv
`timescale 1ns/1ps
module tb_vblend_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_ready;
  logic [1:0]   mode;
  logic         vex_prefix, vex_w, mode32;
  logic [7:0]   imm8;
  logic [255:0] src1, src2, mask;
  logic         out_valid, out_ready;
  logic [255:0] out_data;
  logic [3:0]   out_mask_idx;
  logic         ud_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vblend_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .mode(mode),
    .vex_prefix(vex_prefix), .vex_w(vex_w), .mode32(mode32), .imm8(imm8),
    .src1(src1), .src2(src2), .mask(mask), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_mask_idx(out_mask_idx),
    .ud_flag(ud_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mix(input int unsigned k);
    logic [63:0] x;
    x = {32'(k) * 32'h9E3779B9, 32'(k + 7) * 32'h85EBCA6B};
    x = x ^ (x >> 29);
    return x;
  endfunction

  logic [255:0] last_data;
  logic [3:0]   last_idx;

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    mode = '0; vex_prefix = 1'b0; vex_w = 1'b0; mode32 = 1'b0; imm8 = '0;
    src1 = '0; src2 = '0; mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R12 reset state
    chk(out_valid == 1'b0, "R12", "out_valid", 256'(out_valid), 256'd0);
    chk(out_data == '0, "R12", "out_data", out_data, '0);
    chk(out_mask_idx == '0, "R12", "out_mask_idx", 256'(out_mask_idx), 256'd0);
    chk(ud_flag == 1'b0, "R12", "ud_flag", 256'(ud_flag), 256'd0);
    chk(in_ready == 1'b1, "R11", "in_ready", 256'(in_ready), 256'd1);
    last_data = '0; last_idx = '0;

    // exhaustive sweep of control fields and lane mask patterns
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          for (int b = 0; b < 2; b++)
            for (int hi = 0; hi < 16; hi++)
              for (int pat = 0; pat < 16; pat++) begin
                int unsigned seed;
                bit ill;
                logic [255:0] exp_d;
                logic [3:0] exp_i;
                string rq;
                seed = 32'((((m*2+p)*2+w)*2+b)*256 + hi*16 + pat);
                mode = 2'(m); vex_prefix = p[0]; vex_w = w[0]; mode32 = b[0];
                imm8 = {4'(hi), mix(seed)[3:0]};
                for (int l = 0; l < 4; l++) begin
                  src1[l*64 +: 64] = mix(seed*8 + 32'(l));
                  src2[l*64 +: 64] = mix(seed*8 + 32'(l) + 4);
                  mask[l*64 +: 64] = {pat[l], mix(seed*3 + 32'(l))[62:0]};
                end
                ill = (m == 3) || (m == 0 && p == 1) || (m != 0 && w == 1);
                for (int l = 0; l < 4; l++) begin
                  logic [63:0] bl;
                  bl = pat[l] ? src2[l*64 +: 64] : src1[l*64 +: 64];
                  if (l < 2) exp_d[l*64 +: 64] = bl;
                  else if (m == 0) exp_d[l*64 +: 64] = src1[l*64 +: 64];
                  else if (m == 1) exp_d[l*64 +: 64] = '0;
                  else exp_d[l*64 +: 64] = bl;
                end
                exp_i = (m == 0) ? 4'd0 : (b == 1) ? {1'b0, 3'(hi)} : 4'(hi);
                in_valid = 1'b1;
                @(posedge clk);
                @(negedge clk);
                in_valid = 1'b0;
                if (ill) begin
                  rq = (m == 0) ? "R9 R10" : "R8 R10";
                  chk(ud_flag == 1'b1, rq, "ud_flag", 256'(ud_flag), 256'd1);
                  chk(out_valid == 1'b0, rq, "out_valid", 256'(out_valid), 256'd0);
                  chk(out_data == last_data, "R10", "held data", out_data, last_data);
                  chk(out_mask_idx == last_idx, "R10", "held idx",
                      256'(out_mask_idx), 256'(last_idx));
                end else begin
                  rq = (m == 0) ? "R1 R3" : (m == 1) ? "R1 R4" : "R1 R5";
                  chk(out_valid == 1'b1, "R11", "out_valid", 256'(out_valid), 256'd1);
                  chk(ud_flag == 1'b0, "R8 R9", "ud_flag", 256'(ud_flag), 256'd0);
                  chk(out_data == exp_d, rq, "out_data", out_data, exp_d);
                  rq = (m == 0) ? "R2" : (b == 1) ? "R7" : "R6";
                  chk(out_mask_idx == exp_i, rq, "out_mask_idx",
                      256'(out_mask_idx), 256'(exp_i));
                  last_data = exp_d; last_idx = exp_i;
                end
              end

    // back-pressure: result held while a new operation waits
    out_ready = 1'b0;
    mode = 2'd2; vex_prefix = 1'b0; vex_w = 1'b0; mode32 = 1'b0; imm8 = 8'hA5;
    src1 = {4{64'h1111_2222_3333_4444}}; src2 = {4{64'h5555_6666_7777_8888}};
    mask = {64'h8000_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF};
    last_data = {64'h5555_6666_7777_8888, 64'h1111_2222_3333_4444,
                 64'h5555_6666_7777_8888, 64'h1111_2222_3333_4444};
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(out_data == last_data, "R1 R5", "stall entry data", out_data, last_data);
    chk(out_mask_idx == 4'hA, "R6", "stall entry idx", 256'(out_mask_idx), 256'hA);
    src2 = '1; mask = '1; imm8 = 8'h30;
    for (int c = 0; c < 3; c++) begin
      chk(in_ready == 1'b0, "R11", "in_ready stalled", 256'(in_ready), 256'd0);
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b1, "R11", "valid held", 256'(out_valid), 256'd1);
      chk(out_data == last_data, "R11", "data held", out_data, last_data);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(out_valid == 1'b0, "R11", "valid after drain", 256'(out_valid), 256'd0);

    // reset mid-stream clears everything
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R12", "valid after reset", 256'(out_valid), 256'd0);
    chk(out_data == '0, "R12", "data after reset", out_data, '0);
    chk(out_mask_idx == '0, "R12", "idx after reset", 256'(out_mask_idx), 256'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule